// File: doc/BRIEF.md
# Non-Maskable Error Interrupt Collector with Escalation Watchdog

This block gathers one-clock error strobes from several hardware checkers into sticky flag bits. Once software has switched it on, any latched error raises a global flag and sends a single-clock NMI pulse to the processor. Software reads the flags over a small 16-bit register bus. It clears them with write-one-to-clear semantics and can force source flags on to test its handler. A software-error flag exists that only the force path can set.

While any flag is pending, a 16-bit watchdog counts clock cycles. If the handler does not clear every flag before the count reaches a programmable period, the block emits a one-clock reset request, which the system feeds back as a system reset. A second bank of shadow flags records every flag that was ever set. System reset leaves the shadow flags intact and only power-on reset clears them, so software can find the cause of an escalation after reboot. Writes to the control registers are accepted only while a write-protect release input is high.

The watchdog is a four-state machine:
- **Idle**: the counter is held at zero. It moves to Run when any flag is pending.
- **Run**: the counter advances by one each clock. It returns to Idle when all flags clear. It moves to Fire when the count is at or above the period.
- **Fire**: a one-clock state that drives the reset request. It moves to Hold if flags are still pending, otherwise to Idle.
- **Hold**: the counter stays at zero. It returns to Idle once all flags clear.

Top module: `nmi_aggregator`

## Requirements
- R1: After system plus power-on reset, every register reads 0 except the watchdog period (offset 5), which reads FFFFh. `nmi_out` and `wdog_rst` are low.
- R2: The register map is as follows:
  - offset 0: control
  - offset 1: flags (read-only)
  - offset 2: clear
  - offset 3: force
  - offset 4: watchdog count
  - offset 5: watchdog period
  - offset 6: shadow flags
  
  Offset 7 reads 0 and ignores writes. Offsets 2 and 3 always read 0.
- R3: Control bit 0 is the enable. Writing 1 sets it. Writing 0 does not clear it; only system reset clears it.
- R4: Event inputs latch into flag bits only while the enable is set. The mapping is `evt[0]` to bit 1, `evt[1]` to bit 2, `evt[2]` to bit 3, `evt[3]` to bit 6 and `evt[4]` to bit 8. Bits other than 0, 1, 2, 3, 6, 8 and 13 always read 0.
- R5: The global flag (bit 0) sets together with any source flag while enabled. `nmi_out` pulses for one clock in the cycle the global flag first reads 1, and does not pulse again while the global flag stays set.
- R6: Writing 1 to a clear-register bit clears that flag, and writing 0 leaves it unchanged. An event arriving in the same cycle as a clear of its flag leaves the flag set.
- R7: Clearing the global flag while any source flag is set leaves the global flag reading 1, with no new NMI pulse.
- R8: Writing 1 to a force-register bit sets that source flag even when the block is not enabled. Bit 0 cannot be forced. Bit 13 (software error) can be set only this way.
- R9: The watchdog count (offset 4) reads k in the k-th clock after the first flag latches, and is held at 0 while no flag is set.
- R10: In the clock after the count reads the period value, `wdog_rst` pulses for one clock. The count then reads 0 and stays 0 while flags remain pending.
- R11: Writing a period smaller than the running count makes `wdog_rst` pulse in the next clock.
- R12: Each shadow bit (offset 6) sets when its source flag sets. System reset leaves the shadow bits unchanged, and only power-on reset clears them.
- R13: While `wr_unlock` is low, writes to offsets 0, 2, 3 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Synchronous system reset, active low |
| por_n | input | 1 | Synchronous power-on reset, active low; also acts as system reset |
| bus_addr | input | 3 | Register word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| wr_unlock | input | 1 | Write-protect release for control registers |
| evt | input | 5 | One-clock error event strobes |
| nmi_out | output | 1 | One-clock NMI pulse to the processor |
| wdog_rst | output | 1 | One-clock reset request from the watchdog |

## Verification
Two collisions are provoked on purpose. In the first, an error strobe and a software clear of the same flag are driven in the same clock. The result is judged by the flag still reading set afterwards and an NMI pulse appearing because the global flag rose. In the second, a period write lands while the watchdog is already counting past the new value. It is judged by `wdog_rst` staying low in the write cycle and pulsing in exactly the next one. Further sequences check the clear-order rule for the global flag and check that shadow bits survive a watchdog-driven system reset.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int CNT_W   = 16;
    localparam int NUM_EVT = 5;

    localparam int BIT_GLOB = 0;
    localparam int BIT_SW   = 13;

    // flag bit fed by each event input, in input order
    localparam int EVT_POS [NUM_EVT] = '{1, 2, 3, 6, 8};

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL  = 3'd0,
        OFS_FLAG  = 3'd1,
        OFS_CLR   = 3'd2,
        OFS_FRC   = 3'd3,
        OFS_CNT   = 3'd4,
        OFS_PRD   = 3'd5,
        OFS_SHD   = 3'd6,
        OFS_SPARE = 3'd7
    } reg_ofs_e;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_RUN,
        WD_FIRE,
        WD_HOLD
    } wd_state_e;

    function automatic int evt_index(input int bitpos);
        int idx;
        idx = -1;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (EVT_POS[k] == bitpos) idx = k;
        end
        return idx;
    endfunction

    function automatic logic [DATA_W-1:0] src_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_EVT; k++) m[EVT_POS[k]] = 1'b1;
        m[BIT_SW] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] SRC_MASK = src_mask();

endpackage

// File: rtl/nmi_reg_decode.sv
module nmi_reg_decode
    import nmi_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock,
    output logic              ctrl_set,
    output logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] frc_vec,
    output logic              prd_we
);

    reg_ofs_e ofs;
    logic     wr_ok;

    assign ofs   = reg_ofs_e'(addr);
    assign wr_ok = we & unlock;

    always_comb begin
        ctrl_set = 1'b0;
        clr_vec  = '0;
        frc_vec  = '0;
        prd_we   = 1'b0;
        if (wr_ok) begin
            unique case (ofs)
                OFS_CTRL: ctrl_set = wdata[0];
                OFS_CLR:  clr_vec  = wdata;
                OFS_FRC:  frc_vec  = wdata & SRC_MASK;
                OFS_PRD:  prd_we   = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank
    import nmi_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              por_rst,
    input  logic              ctrl_set,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [DATA_W-1:0] clr_vec,
    input  logic [DATA_W-1:0] frc_vec,
    output logic              en_q,
    output logic [DATA_W-1:0] flags_q,
    output logic [DATA_W-1:0] shadow_q,
    output logic              nmi_pulse
);

    logic [DATA_W-1:0] evt_map;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] src_d;
    logic              glob_q;
    logic              glob_d;

    for (genvar i = 0; i < DATA_W; i++) begin : g_map
        if (evt_index(i) >= 0) begin : g_hit
            assign evt_map[i] = evt[evt_index(i)];
        end else begin : g_miss
            assign evt_map[i] = 1'b0;
        end
    end

    assign src_q   = flags_q & SRC_MASK;
    assign glob_q  = flags_q[BIT_GLOB];
    assign set_vec = ((en_q ? evt_map : '0) | frc_vec) & SRC_MASK;
    // set has priority over a clear in the same cycle
    assign src_d   = (src_q & ~clr_vec) | set_vec;
    // global re-arms while any source flag is still pending
    assign glob_d  = (glob_q & ~clr_vec[BIT_GLOB]) |
                     (en_q & ((|src_q) | (|set_vec)));

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            en_q      <= 1'b0;
            flags_q   <= '0;
            nmi_pulse <= 1'b0;
        end else begin
            en_q      <= en_q | ctrl_set;
            flags_q   <= src_d | {{(DATA_W-1){1'b0}}, glob_d};
            nmi_pulse <= glob_d & ~glob_q;
        end
    end

    always_ff @(posedge clk) begin
        if (por_rst) shadow_q <= '0;
        else         shadow_q <= shadow_q | set_vec;
    end

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (sys_rst)
        en_q |=> en_q); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (sys_rst)
        ((set_vec & clr_vec) != '0) |=> ((flags_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec))); // R6

    AST_GLOB_REARM: assert property (@(posedge clk) disable iff (sys_rst)
        (en_q && (src_q != '0)) |=> flags_q[BIT_GLOB]); // R7

    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (sys_rst)
        nmi_pulse |=> !nmi_pulse); // R5

    AST_SHADOW_COVERS: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
        ((flags_q & SRC_MASK & ~shadow_q) == '0)); // R12

endmodule

// File: rtl/nmi_wdog.sv
module nmi_wdog
    import nmi_pkg::*;
#(
    parameter logic [CNT_W-1:0] PRD_INIT = '1
)(
    input  logic             clk,
    input  logic             sys_rst,
    input  logic             any_flag,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] prd_q,
    output logic             wd_rst
);

    wd_state_e        state_q;
    wd_state_e        state_d;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk) begin
        if (sys_rst) state_q <= WD_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            WD_IDLE: begin
                if (any_flag) begin
                    state_d = WD_RUN;
                    cnt_d   = CNT_W'(1);
                end
            end
            WD_RUN: begin
                if (!any_flag)            state_d = WD_IDLE;
                else if (cnt_q >= prd_q)  state_d = WD_FIRE;
                else                      cnt_d   = cnt_q + CNT_W'(1);
            end
            WD_FIRE: state_d = any_flag ? WD_HOLD : WD_IDLE;
            WD_HOLD: if (!any_flag) state_d = WD_IDLE;
            default: state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            cnt_q <= '0;
            prd_q <= PRD_INIT;
        end else begin
            cnt_q <= cnt_d;
            if (prd_we) prd_q <= prd_wdata;
        end
    end

    always_comb begin
        wd_rst = (state_q == WD_FIRE);
    end

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (sys_rst)
        !any_flag |=> (cnt_q == '0)); // R9

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (sys_rst)
        wd_rst |=> !wd_rst); // R10

    AST_STOP_AFTER: assert property (@(posedge clk) disable iff (sys_rst)
        wd_rst |-> (cnt_q == '0)); // R10

    AST_PRD_BELOW: assert property (@(posedge clk) disable iff (sys_rst)
        (any_flag && (cnt_q > prd_q)) |=> wd_rst); // R11

endmodule

// File: rtl/nmi_aggregator.sv
module nmi_aggregator
    import nmi_pkg::*;
#(
    parameter logic [CNT_W-1:0] PRD_INIT = '1
)(
    input  logic               clk,
    input  logic               sys_rst_n,
    input  logic               por_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               wr_unlock,
    input  logic [NUM_EVT-1:0] evt,
    output logic               nmi_out,
    output logic               wdog_rst
);

    logic              sys_rst;
    logic              por_rst;
    logic              ctrl_set;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] frc_vec;
    logic              prd_we;
    logic              en_q;
    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] shadow_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  prd_q;

    assign por_rst = ~por_n;
    assign sys_rst = ~sys_rst_n | por_rst;

    nmi_reg_decode u_dec (
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .unlock   (wr_unlock),
        .ctrl_set (ctrl_set),
        .clr_vec  (clr_vec),
        .frc_vec  (frc_vec),
        .prd_we   (prd_we)
    );

    nmi_flag_bank u_flags (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .por_rst   (por_rst),
        .ctrl_set  (ctrl_set),
        .evt       (evt),
        .clr_vec   (clr_vec),
        .frc_vec   (frc_vec),
        .en_q      (en_q),
        .flags_q   (flags_q),
        .shadow_q  (shadow_q),
        .nmi_pulse (nmi_out)
    );

    nmi_wdog #(.PRD_INIT(PRD_INIT)) u_wdog (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .any_flag  (|flags_q),
        .prd_we    (prd_we),
        .prd_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .prd_q     (prd_q),
        .wd_rst    (wdog_rst)
    );

    always_comb begin
        unique case (reg_ofs_e'(bus_addr))
            OFS_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
            OFS_FLAG: bus_rdata = flags_q;
            OFS_CNT:  bus_rdata = cnt_q;
            OFS_PRD:  bus_rdata = prd_q;
            OFS_SHD:  bus_rdata = shadow_q;
            default:  bus_rdata = '0;
        endcase
    end

    AST_LOCKED_PRD: assert property (@(posedge clk) disable iff (sys_rst)
        (!wr_unlock) |=> $stable(prd_q)); // R13

    AST_LOCKED_EN: assert property (@(posedge clk) disable iff (sys_rst)
        (!wr_unlock && !en_q) |=> !en_q); // R13

endmodule

// File: tb/sim_nmi_aggregator.sv
module sim_nmi_aggregator;

    typedef struct {
        int          kind;   // 0 rdata, 1 nmi_out, 2 wdog_rst
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        tb_sys_n = 1'b0;
    logic        por_n = 1'b0;
    logic        fb_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wr_unlock = 1'b0;
    logic [4:0]  evt = '0;
    logic        nmi_out;
    logic        wdog_rst;
    logic        sys_rst_n;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    assign sys_rst_n = tb_sys_n & ~(fb_en & wdog_rst);

    nmi_aggregator u0 (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .por_n     (por_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wr_unlock (wr_unlock),
        .evt       (evt),
        .nmi_out   (nmi_out),
        .wdog_rst  (wdog_rst)
    );

    // monitor: pops every expected item due in this cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = (it.kind == 0) ? bus_rdata :
                  (it.kind == 1) ? {15'b0, nmi_out} : {15'b0, wdog_rst};
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h t=%0t",
                         it.tag, it.kind, act, it.exp, $time);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog timeout actual=%0d expected<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input int kind, input logic [2:0] a,
                       input logic [15:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [4:0] e);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; evt = e;
        @(posedge clk); #1;
        bus_we = 1'b0; evt = '0;
    endtask

    task automatic pulse_evt(input logic [4:0] e);
        @(posedge clk); #1;
        evt = e;
        @(posedge clk); #1;
        evt = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        idle(3);
        por_n = 1'b1; tb_sys_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(0, 3'd0, 16'h0000, "R1 ctrl");
        chk(0, 3'd1, 16'h0000, "R1 flags");
        chk(0, 3'd4, 16'h0000, "R1 count");
        chk(0, 3'd5, 16'hFFFF, "R1 period");
        chk(0, 3'd6, 16'h0000, "R1 shadow");
        chk(1, 3'd0, 16'h0000, "R1 nmi");
        chk(2, 3'd0, 16'h0000, "R1 wdog");

        // R13 locked writes ignored
        wr(3'd0, 16'h0001, '0);
        wr(3'd5, 16'h0010, '0);
        wr(3'd3, 16'h0002, '0);
        chk(0, 3'd0, 16'h0000, "R13 ctrl locked");
        chk(0, 3'd5, 16'hFFFF, "R13 period locked");
        chk(0, 3'd1, 16'h0000, "R13 force locked");

        // R2 spare offset and write-only registers
        wr_unlock = 1'b1;
        wr(3'd7, 16'hFFFF, '0);
        chk(0, 3'd7, 16'h0000, "R2 spare");
        chk(0, 3'd2, 16'h0000, "R2 clear reads 0");

        // R4 events ignored while disabled
        pulse_evt(5'h1F);
        chk(0, 3'd1, 16'h0000, "R4 disabled");

        // R3 enable sticky
        wr(3'd0, 16'h0001, '0);
        chk(0, 3'd0, 16'h0001, "R3 set");
        wr(3'd0, 16'h0000, '0);
        chk(0, 3'd0, 16'h0001, "R3 zero write");

        // R4 R5 event latch and NMI pulse
        pulse_evt(5'b00001);
        chk(0, 3'd1, 16'h0003, "R4 clock-fail flag");
        chk(1, 3'd1, 16'h0000, "R5 pulse one clock");
        pulse_evt(5'b01000);
        chk(1, 3'd1, 16'h0000, "R5 no second pulse");
        chk(0, 3'd1, 16'h0043, "R4 vector flag");

        // R7 global re-arms while sources pending
        wr(3'd2, 16'h0001, '0);
        chk(0, 3'd1, 16'h0043, "R7 global stays");
        chk(1, 3'd1, 16'h0000, "R7 no new pulse");

        // R6 clear semantics
        wr(3'd2, 16'h0042, '0);
        chk(0, 3'd1, 16'h0001, "R6 sources cleared");
        wr(3'd2, 16'h0001, '0);
        chk(0, 3'd1, 16'h0000, "R6 global cleared");
        wr(3'd2, 16'h0004, 5'b00010);
        chk(1, 3'd1, 16'h0001, "R6 pulse on set-wins");
        chk(0, 3'd1, 16'h0005, "R6 set wins");
        wr(3'd2, 16'h0004, '0);
        wr(3'd2, 16'h0001, '0);
        chk(0, 3'd1, 16'h0000, "R6 cleared again");

        // R8 force
        wr(3'd3, 16'hFFFF, '0);
        chk(0, 3'd1, 16'h214F, "R8 force all");
        chk(0, 3'd3, 16'h0000, "R8 force reads 0");
        chk(0, 3'd6, 16'h214E, "R12 shadow set");
        wr(3'd2, 16'h214E, '0);
        wr(3'd2, 16'h0001, '0);
        chk(0, 3'd1, 16'h0000, "R8 cleared");

        // R9 R10 watchdog expiry, no feedback
        wr(3'd5, 16'h0005, '0);
        wr(3'd3, 16'h0002, '0);
        chk(0, 3'd4, 16'h0000, "R9 count 0");
        chk(0, 3'd4, 16'h0001, "R9 count 1");
        chk(0, 3'd4, 16'h0002, "R9 count 2");
        chk(0, 3'd4, 16'h0003, "R9 count 3");
        chk(0, 3'd4, 16'h0004, "R9 count 4");
        chk(0, 3'd4, 16'h0005, "R9 count 5");
        chk(2, 3'd4, 16'h0001, "R10 wdog pulse");
        chk(2, 3'd4, 16'h0000, "R10 wdog one clock");
        idle(3);
        chk(0, 3'd4, 16'h0000, "R10 count stopped");
        chk(0, 3'd1, 16'h0003, "R10 flags pending");
        wr(3'd2, 16'h0002, '0);
        wr(3'd2, 16'h0001, '0);
        idle(1);
        chk(0, 3'd4, 16'h0000, "R9 held at zero");

        // R11 period written below count
        wr(3'd5, 16'hFFFF, '0);
        wr(3'd3, 16'h0008, '0);
        idle(10);
        wr(3'd5, 16'h0003, '0);
        chk(2, 3'd0, 16'h0000, "R11 write cycle");
        chk(2, 3'd0, 16'h0001, "R11 immediate reset");
        wr(3'd2, 16'h0008, '0);
        wr(3'd2, 16'h0001, '0);

        // R12 shadow survives watchdog-driven system reset
        fb_en = 1'b1;
        wr(3'd5, 16'h0002, '0);
        wr(3'd3, 16'h2000, '0);
        idle(6);
        chk(0, 3'd0, 16'h0000, "R12 enable reset");
        chk(0, 3'd1, 16'h0000, "R12 flags reset");
        chk(0, 3'd5, 16'hFFFF, "R12 period reset");
        chk(0, 3'd6, 16'h214E, "R12 shadow kept");
        por_n = 1'b0;
        idle(2);
        por_n = 1'b1;
        idle(1);
        chk(0, 3'd6, 16'h0000, "R12 power-on clears");

        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule